// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from eleven sources for a small 8-bit processor core. It selects the most urgent one and presents it to the core as an interrupt line and a source number. The sources are a USB/PS2 event, a 128 µs tick, a 1 ms tick, three USB endpoint events, SPI, two timer captures, a GPIO aggregate and wake-up.

Every source has a sticky pending latch. A latch reaches the selector only when its enable bit is set. A global enable, controlled by the core's enable, disable and return-from-interrupt operations, gates the interrupt line. When the core acknowledges an interrupt, only the latch of the source being served is cleared, and the global enable drops until the core turns it on again.

The GPIO source is fed by per-pin events from two 8-bit ports. Each port has its own write-only mask register that selects which pins may raise the GPIO request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all pending latches, the enable registers at 0x20 and 0x21, both pin masks and the global enable are zero, `irq` is low, and every register reads 0.
- R2: A high `src_evt[i]` on a clock edge sets pending latch i. The latch holds until that source is served. `irq` rises in the cycle after the event when the source is enabled and the global enable is set.
- R3: Enable bits are mapped to sources as follows. At 0x20: bit0 USB/PS2, bit1 128 µs, bit2 1 ms, bit3 GPIO, bit4 capture A, bit5 capture B, bit6 SPI, bit7 wake-up. At 0x21: bits 0 to 2 are endpoints 0 to 2. A disabled source stays latched and does not affect `irq`, `vector` or the pending bit in 0xFF.
- R4: `vector` is the index of the highest-priority enabled pending source. Indexes run from 0 (highest) to 10: USB/PS2, 128 µs, 1 ms, EP0, EP1, EP2, SPI, capture A, capture B, GPIO, wake-up. `vector` is 0 whenever `irq` is low.
- R5: `ei` and `reti` set the global enable; `di` clears it. If a clearing and a setting operation arrive together, clearing wins. The global enable reads as bit 2 of 0xFF, and `irq` is low whenever it is clear.
- R6: An `ack` while `irq` is high clears only the latch named by `vector`, and it clears the global enable. An `ack` while `irq` is low has no effect.
- R7: If a source's event arrives in the same cycle as the acknowledge that clears that source, the latch stays set.
- R8: Pin masks are written at 0x04 (port 0) and 0x05 (port 1) and read back as 0. The GPIO latch (index 9) is set when any pin event has its mask bit set. `src_evt[9]` is ignored.
- R9: Bit 7 of 0xFF is high when any enabled source is pending, regardless of the global enable. 0x20 reads back all 8 bits and 0x21 reads back bits 2:0. Writes to 0xFF are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 11 | Per-source event strobes, indexed by priority; bit 9 unused |
| p0_evt | input | 8 | Port 0 pin event strobes |
| p1_evt | input | 8 | Port 1 pin event strobes |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ei | input | 1 | Set global enable |
| di | input | 1 | Clear global enable |
| reti | input | 1 | Return from interrupt: set global enable |
| ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 4 | Winning source index |

## Verification
Every event, register write and control strobe is sampled on one rising edge. Its effect on `irq`, `vector` and the read data is due after that edge, because those outputs are combinational from the latches. The bench applies stimulus just after a falling edge and advances its reference model at the rising edge. It compares all three outputs at the next falling edge, so each result is checked exactly one edge after its cause. Acknowledge cases, including an acknowledge that coincides with a new event, are judged against model state from before that edge.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [10:0]     src_evt,
  input  logic [PINS-1:0] p0_evt,
  input  logic [PINS-1:0] p1_evt,
  input  logic [7:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            reg_we,
  output logic [7:0]      reg_rdata,
  input  logic            ei,
  input  logic            di,
  input  logic            reti,
  input  logic            ack,
  output logic            irq,
  output logic [3:0]      vector
);
  localparam int NSRC = 11;
  localparam int GPIO_IDX = 9;

  logic [NSRC-1:0] pend_q;
  logic [7:0]      en_lo_q;
  logic [2:0]      en_hi_q;
  logic [PINS-1:0] mask0_q, mask1_q;
  logic            gie_q;

  wire [NSRC-1:0] en_map = {en_lo_q[7], en_lo_q[3], en_lo_q[5], en_lo_q[4], en_lo_q[6],
                            en_hi_q[2], en_hi_q[1], en_hi_q[0],
                            en_lo_q[2], en_lo_q[1], en_lo_q[0]};
  wire [NSRC-1:0] active = pend_q & en_map;
  wire            any_act = |active;

  logic [3:0] win;
  always_comb begin
    win = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (active[i]) win = 4'(i);
  end

  assign irq    = gie_q & any_act;
  assign vector = irq ? win : 4'd0;

  wire             ack_ok   = ack & irq;
  wire             gpio_hit = |(p0_evt & mask0_q) | |(p1_evt & mask1_q);
  wire [NSRC-1:0]  set_v    = {src_evt[10], gpio_hit, src_evt[8:0]};
  wire [NSRC-1:0]  clr_v    = ack_ok ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               gie_q <= 1'b0;
    else if (di || ack_ok)    gie_q <= 1'b0;
    else if (ei || reti)      gie_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_lo_q <= '0;
      en_hi_q <= '0;
      mask0_q <= '0;
      mask1_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        8'h04:   mask0_q <= reg_wdata[PINS-1:0];
        8'h05:   mask1_q <= reg_wdata[PINS-1:0];
        8'h20:   en_lo_q <= reg_wdata;
        8'h21:   en_hi_q <= reg_wdata[2:0];
        default: ;
      endcase
    end

  always_comb begin
    case (reg_addr)
      8'h20:   reg_rdata = en_lo_q;
      8'h21:   reg_rdata = {5'b0, en_hi_q};
      8'hFF:   reg_rdata = {any_act, 4'b0, gie_q, 2'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !gie_q |-> !irq); // R5
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (vector < 4'(NSRC))); // R4
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq |-> (vector == 4'd0)); // R4
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n) (ack && irq) |=> !gie_q); // R6
  AST_ACK_CLEARS_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !set_v[win]) |=> !pend_q[$past(win)]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v))); // R7
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2
  AST_DI_WINS: assert property (@(posedge clk) disable iff (!rst_n) (di && (ei || reti)) |=> !gie_q); // R5
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [10:0] src_evt = 0;
  logic [7:0] p0_evt = 0, p1_evt = 0, reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_we = 0, ei = 0, di = 0, reti = 0, ack = 0, irq;
  logic [3:0] vector;

  irq_prio_ctrl uut (.clk, .rst_n, .src_evt, .p0_evt, .p1_evt, .reg_addr, .reg_wdata,
                     .reg_we, .reg_rdata, .ei, .di, .reti, .ack, .irq, .vector);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R1";

  // reference state
  bit m_pend[11];
  int m_lo, m_hi, m_k0, m_k1;
  bit m_gie;

  function automatic bit en_of(int i);
    case (i)
      0: return m_lo[0]; 1: return m_lo[1]; 2: return m_lo[2];
      3: return m_hi[0]; 4: return m_hi[1]; 5: return m_hi[2];
      6: return m_lo[6]; 7: return m_lo[4]; 8: return m_lo[5];
      9: return m_lo[3]; default: return m_lo[7];
    endcase
  endfunction

  function automatic int winner();
    for (int i = 0; i < 11; i++) if (m_pend[i] && en_of(i)) return i;
    return -1;
  endfunction

  function automatic int exp_rdata();
    int w = winner();
    case (reg_addr)
      8'h20: return m_lo;
      8'h21: return m_hi;
      8'hFF: return ((w >= 0) ? 128 : 0) + (m_gie ? 4 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", phase, what, got, exp);
    end
  endtask

  task automatic model_step();
    int w = winner();
    bit m_irq = m_gie && (w >= 0);
    bit ackok = ack && m_irq;
    bit g = ((p0_evt & m_k0[7:0]) != 0) || ((p1_evt & m_k1[7:0]) != 0);
    for (int i = 0; i < 11; i++) begin
      bit s = (i == 9) ? g : src_evt[i];
      bit c = ackok && (i == w);
      m_pend[i] = s || (m_pend[i] && !c);
    end
    if (di || ackok) m_gie = 0; else if (ei || reti) m_gie = 1;
    if (reg_we)
      case (reg_addr)
        8'h04: m_k0 = reg_wdata; 8'h05: m_k1 = reg_wdata;
        8'h20: m_lo = reg_wdata; 8'h21: m_hi = reg_wdata & 7;
        default: ;
      endcase
  endtask

  task automatic compare();
    int w = winner();
    bit e_irq = m_gie && (w >= 0);
    check("irq", irq, e_irq);
    check("vector", vector, e_irq ? w : 0);
    check("rdata", reg_rdata, exp_rdata());
  endtask

  // one clock: inputs already driven; returns at the falling edge after compare, pulses cleared
  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
    src_evt = 0; p0_evt = 0; p1_evt = 0; reg_we = 0;
    ei = 0; di = 0; reti = 0; ack = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; cyc();
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a; @(negedge clk); compare();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_lo = 0; m_hi = 0; m_k0 = 0; m_k1 = 0; m_gie = 0;
    foreach (m_pend[i]) m_pend[i] = 0;
    // R1: reset state, stimulus held off
    phase = "R1";
    repeat (3) @(negedge clk);
    src_evt = 11'h7FF; ei = 1;
    @(negedge clk);
    foreach (m_pend[i]) m_pend[i] = 0;
    compare();
    src_evt = 0; ei = 0;
    rst_n = 1;
    rd(8'h20); rd(8'h21); rd(8'hFF); rd(8'h04); rd(8'h05);

    // R5: global enable control
    phase = "R5";
    reg_addr = 8'hFF;
    ei = 1; cyc();
    di = 1; cyc();
    reti = 1; cyc();
    di = 1; ei = 1; cyc();
    ei = 1; cyc();
    di = 1; reti = 1; cyc();

    // R3/R9: latch everything with enables off, then open them one at a time
    phase = "R3";
    src_evt = 11'h7FF; cyc();
    ei = 1; cyc();
    rd(8'hFF);
    for (int b = 7; b >= 0; b--) begin
      wr(8'h20, 8'(1 << b)); rd(8'hFF);
    end
    for (int b = 2; b >= 0; b--) begin
      wr(8'h20, 0); wr(8'h21, 8'(1 << b)); rd(8'hFF); rd(8'h21);
    end
    phase = "R9";
    wr(8'hFF, 8'h00); rd(8'hFF);
    wr(8'h21, 8'hFF); rd(8'h21);
    rd(8'h33);
    wr(8'h21, 8'h00);

    // R8: GPIO masks, src_evt[9] ignored
    phase = "R8";
    wr(8'h20, 8'h08);
    src_evt = 11'h200; cyc();
    p0_evt = 8'hFF; cyc();
    wr(8'h04, 8'h10); rd(8'h04);
    p0_evt = 8'hEF; p1_evt = 8'hFF; cyc();
    p0_evt = 8'h10; cyc();
    wr(8'h05, 8'h81); rd(8'h05);
    reg_addr = 8'hFF; ack = 1; cyc();
    reti = 1; cyc();
    p1_evt = 8'h01; cyc();
    ack = 1; cyc();
    reti = 1; cyc();
    p1_evt = 8'h80; cyc();

    // R4: full priority walk with everything enabled
    phase = "R4";
    wr(8'h20, 8'hFF); wr(8'h21, 8'h07);
    src_evt = 11'h7FF; p0_evt = 8'h10; cyc();
    reti = 1; cyc();
    for (int k = 0; k < 12; k++) begin
      ack = 1; cyc();
      reti = 1; cyc();
    end

    // R6: ack with irq low has no effect; ack serves only the winner
    phase = "R6";
    src_evt = 11'h0A0; cyc();
    di = 1; cyc();
    ack = 1; cyc();
    ack = 1; cyc();
    ei = 1; cyc();
    ack = 1; cyc();
    ei = 1; cyc();

    // R7: event coincident with its own clear
    phase = "R7";
    src_evt = 11'h080; ack = 1; cyc();
    ei = 1; cyc();
    ack = 1; cyc();
    ei = 1; cyc();

    // R2: single events rise irq one cycle later
    phase = "R2";
    for (int i = 0; i < 11; i++) begin
      if (i == 9) continue;
      src_evt = 11'(1 << i); cyc();
      ack = 1; cyc();
      ei = 1; cyc();
    end

    // mixed traffic
    phase = "R4";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 16;
      src_evt = ($urandom % 4 == 0) ? 11'($urandom) : 11'h0;
      p0_evt = ($urandom % 6 == 0) ? 8'($urandom) : 8'h0;
      p1_evt = ($urandom % 6 == 0) ? 8'($urandom) : 8'h0;
      ack = ($urandom % 3 == 0);
      ei = (r == 0); di = (r == 1); reti = (r == 2) || (r == 3);
      reg_addr = 8'hFF;
      if (r == 4) begin
        reg_we = 1;
        case ($urandom % 5)
          0: reg_addr = 8'h20; 1: reg_addr = 8'h21; 2: reg_addr = 8'h04;
          3: reg_addr = 8'h05; default: reg_addr = 8'hFF;
        endcase
        reg_wdata = 8'($urandom);
      end
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule